// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Clock Divider

This block divides an input clock by a ratio that may carry a fractional part. Each output period is exactly N or N+1 input cycles long. The choice for the next period is made at the end of the current one. A first-order accumulator adds a 16-bit fraction word K at every period end. A carry out of that add selects the longer period. Over many periods, the average ratio is N + K/65536.

A synthesizer loop can feed the divided pulse to its phase comparator. The square-wave output serves as a near-50% clock. The modulus flag shows which ratio the running period uses.

A fixed fraction gives a strictly repeating short/long pattern, which shows up as spurs. An optional dither mode adds one pseudo-random bit to the accumulator LSB at each period end. This breaks up the pattern while leaving the long-run proportion of long periods essentially unchanged.

Top module: `fracn_div`

## Requirements
- R1: While reset is held, `div_pulse` and `mod_hi` are 0. Reset clears the cycle counter and the accumulator, so the first period after reset uses N (`mod_hi` = 0 at its pulse).
- R2: Every output period lasts N or N+1 input cycles. `mod_hi` is 1 exactly when the period is N+1 long, and it stays constant for the whole period.
- R3: At each period end, the 16-bit accumulator takes acc + K (+ dither bit). A carry out of bit 15 makes the next period N+1; no carry makes it N.
- R4: With dither off, among the 65536 periods that follow the first period after reset, exactly K periods are N+1 long.
- R5: `div_pulse` is high for exactly one input cycle, on the last cycle of each period.
- R6: In a period of M cycles, `div_sq` is high for the first floor(M/2) cycles and low for the rest.
- R7: With `dither_en` = 1, the dither source is a 16-bit shift register with feedback from bits 16, 14, 13 and 11 (mask 0xB400 on bits 15..0). It shifts left with the feedback entering bit 0, is set to 0xACE1 on reset, and advances once per period end. Its bit 15, taken before the shift, is added at the accumulator LSB. Over the same 65536 periods as R4, the count of N+1 periods stays within 2 of K, and the long/short sequence differs from the undithered one.
- R8: `n_div` is read only on the first cycle of a period. A change in mid-period does not alter the running period's length, and it takes effect from the next period.
- R9: A value of `n_div` below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| n_div | input | 12 | Integer ratio N (values below 2 act as 2) |
| k_frac | input | 16 | Fraction word K; average ratio is N + K/65536 |
| dither_en | input | 1 | Enables pseudo-random LSB dither of the accumulator |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each period |
| div_sq | output | 1 | Square wave, high for the first floor(M/2) cycles of an M-cycle period |
| mod_hi | output | 1 | 1 while the running period is N+1 cycles long |

## Verification
A zero fraction with both odd and even N pins down the plain integer path: period length, pulse placement and square-wave split. Fractions of one half and near one are compared period by period against an accumulator model. These runs show whether carries select the longer period at the right boundary. A mid-period change of N, and N values of 0 and 1, cover the sampling point and the lower clamp. A full 65536-period run is made twice in parallel, with dither off and on. The undithered run must hit K exactly. The dithered run must follow the shift-register model, stay near K and depart from the undithered pattern.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned FD_MIN_N     = 2;
  localparam int unsigned FD_LFSR_W    = 16;
  localparam logic [15:0] FD_LFSR_SEED = 16'hACE1;
  localparam logic [15:0] FD_LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/fd_rst_sync.sv
module fd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fd_lfsr.sv
module fd_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic bit_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = adv ? {state_q[W-2:0], fb} : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign bit_o = state_q[W-1];

  assert_state_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/fd_modulus_ctl.sv
module fd_modulus_ctl #(
  parameter int unsigned FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic [FW-1:0] k_in,
  input  logic          dith,
  output logic          mod_q
);
  logic [FW-1:0] acc_q;
  logic [FW-1:0] acc_d;
  logic [FW:0]   sum;
  logic          mod_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, k_in} + {{FW{1'b0}}, dith};
    acc_d = boundary ? sum[FW-1:0] : acc_q;
    mod_d = boundary ? sum[FW]     : mod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mod_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      mod_q <= mod_d;
    end
  end

  assert_no_carry_on_zero_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (k_in == '0) && !dith) |=> !mod_q);
endmodule

// File: rtl/fd_period_ctr.sv
module fd_period_ctr #(
  parameter int unsigned NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_eff,
  input  logic          mod_cur,
  output logic          pulse,
  output logic          sq
);
  localparam int unsigned CW = NW + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q;
  logic [CW-1:0] len_cur;
  logic [CW-1:0] half;
  logic          start;
  logic          last;

  always_comb begin
    start   = (cnt_q == '0);
    len_cur = start ? ({1'b0, n_eff} + {{NW{1'b0}}, mod_cur}) : len_q;
    last    = (cnt_q == (len_cur - ONE));
    half    = len_cur >> 1;
    cnt_d   = last ? '0 : (cnt_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (start) len_q <= len_cur;
    end
  end

  assign pulse = last;
  assign sq    = (cnt_q < half);

  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < len_q));
  assert_pulse_not_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cnt_q != '0));
endmodule

// File: rtl/fracn_div.sv
module fracn_div
  import fracn_pkg::*;
#(
  parameter int unsigned NW         = 12,
  parameter int unsigned FW         = 16,
  parameter bit          HAS_DITHER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_div,
  input  logic [FW-1:0] k_frac,
  input  logic          dither_en,
  output logic          div_pulse,
  output logic          div_sq,
  output logic          mod_hi
);
  localparam logic [NW-1:0] N_FLOOR = NW'(FD_MIN_N);

  logic          rst_sync_n;
  logic [NW-1:0] n_eff;
  logic          dith_bit;

  fd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb n_eff = (n_div < N_FLOOR) ? N_FLOOR : n_div;

  generate
    if (HAS_DITHER) begin : g_dither
      logic lfsr_bit;
      fd_lfsr #(
        .W    (FD_LFSR_W),
        .SEED (FD_LFSR_SEED),
        .TAPS (FD_LFSR_TAPS)
      ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .adv   (div_pulse & dither_en),
        .bit_o (lfsr_bit)
      );
      assign dith_bit = lfsr_bit & dither_en;
    end else begin : g_plain
      assign dith_bit = 1'b0;
    end
  endgenerate

  fd_modulus_ctl #(.FW(FW)) u_mod (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .boundary (div_pulse),
    .k_in     (k_frac),
    .dith     (dith_bit),
    .mod_q    (mod_hi)
  );

  fd_period_ctr #(.NW(NW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .n_eff   (n_eff),
    .mod_cur (mod_hi),
    .pulse   (div_pulse),
    .sq      (div_sq)
  );

  assert_mod_holds_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !div_pulse |=> $stable(mod_hi));
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_pulse |=> !div_pulse);
  assert_sq_low_at_end_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_pulse |-> !div_sq);
endmodule

// File: tb/test_fracn_div.sv
module test_fracn_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] n_div = 12'd5;
  logic [15:0] k_frac = 16'd0;
  logic        pulse0, sq0, mh0;
  logic        pulse1, sq1, mh1;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fracn_div i_fracn_div (
    .clk(clk), .rst_n(rst_n), .n_div(n_div), .k_frac(k_frac), .dither_en(1'b0),
    .div_pulse(pulse0), .div_sq(sq0), .mod_hi(mh0));

  fracn_div i_fracn_div_dith (
    .clk(clk), .rst_n(rst_n), .n_div(n_div), .k_frac(k_frac), .dither_en(1'b1),
    .div_pulse(pulse1), .div_sq(sq1), .mod_hi(mh1));

  // long-run monitors: models of R3 / R7 arithmetic, run per period
  logic        mon_en = 1'b0;
  int          idx0, idx1, cnt0, cnt1, mis0, mis1;
  logic [15:0] acc0, acc1, lf1;
  logic        exp0, exp1;
  logic        seq0 [0:65535];
  logic        seq1 [0:65535];

  always @(negedge clk) begin
    if (!mon_en) begin
      idx0 = 0; cnt0 = 0; mis0 = 0; acc0 = '0; exp0 = 1'b0;
    end else if (pulse0 && idx0 <= 65536) begin
      logic [16:0] s;
      if (mh0 !== exp0) mis0++;
      if (idx0 >= 1) begin cnt0 += int'(mh0); seq0[idx0-1] = mh0; end
      s = {1'b0, acc0} + {1'b0, k_frac};
      exp0 = s[16]; acc0 = s[15:0];
      idx0++;
    end
  end

  always @(negedge clk) begin
    if (!mon_en) begin
      idx1 = 0; cnt1 = 0; mis1 = 0; acc1 = '0; exp1 = 1'b0; lf1 = 16'hACE1;
    end else if (pulse1 && idx1 <= 65536) begin
      logic [16:0] s;
      if (mh1 !== exp1) mis1++;
      if (idx1 >= 1) begin cnt1 += int'(mh1); seq1[idx1-1] = mh1; end
      s = {1'b0, acc1} + {1'b0, k_frac} + {16'd0, lf1[15]};
      exp1 = s[16]; acc1 = s[15:0];
      lf1 = {lf1[14:0], ^(lf1 & 16'hB400)};
      idx1++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!pulse0 && guard < 20000);
  endtask

  task automatic measure_period(output int len, output int hi, output logic mh);
    len = 0; hi = 0; mh = 1'b0;
    do begin
      @(negedge clk);
      len++;
      if (sq0) hi++;
      mh = mh0;
    end while (!pulse0 && len < 20000);
  endtask

  task automatic do_reset(input logic [11:0] n, input logic [15:0] k);
    @(negedge clk);
    rst_n = 1'b0; n_div = n; k_frac = k;
    repeat (3) @(negedge clk);
    chk(pulse0 == 1'b0, "R1", "pulse in reset", int'(pulse0), 0);
    chk(mh0 == 1'b0, "R1", "mod flag in reset", int'(mh0), 0);
    rst_n = 1'b1;
    wait_pulse();
    chk(mh0 == 1'b0, "R1", "first period uses N", int'(mh0), 0);
  endtask

  task automatic test_integer(input logic [11:0] n);
    int len, hi; logic mh;
    do_reset(n, 16'd0);
    for (int p = 0; p < 4; p++) begin
      measure_period(len, hi, mh);
      chk(len == int'(n), "R2", "integer period length", len, int'(n));
      chk(mh == 1'b0, "R2", "integer mod flag", int'(mh), 0);
      chk(hi == int'(n) / 2, "R6", "square high cycles", hi, int'(n) / 2);
    end
  endtask

  task automatic test_fraction(input logic [11:0] n, input logic [15:0] k, input int periods);
    int len, hi, m; logic mh; logic [15:0] acc; logic [16:0] s; logic e;
    do_reset(n, k);
    acc = '0;
    for (int p = 0; p < periods; p++) begin
      s = {1'b0, acc} + {1'b0, k};
      e = s[16]; acc = s[15:0];
      m = int'(n) + int'(e);
      measure_period(len, hi, mh);
      chk(len == m, "R3", "fractional period length", len, m);
      chk(mh == e, "R2", "mod flag matches length", int'(mh), int'(e));
      chk(hi == m / 2, "R6", "square high in fractional period", hi, m / 2);
    end
  endtask

  task automatic test_resample();
    int len, hi; logic mh;
    do_reset(12'd9, 16'd0);
    repeat (3) @(negedge clk);
    n_div = 12'd4;
    len = 0;
    do begin @(negedge clk); len++; end while (!pulse0 && len < 100);
    chk(len == 6, "R8", "running period keeps old N", len, 6);
    measure_period(len, hi, mh);
    chk(len == 4, "R8", "new N applied next period", len, 4);
    chk(hi == 2, "R6", "square high for N=4", hi, 2);
  endtask

  task automatic test_clamp(input logic [11:0] n);
    int len, hi; logic mh;
    do_reset(n, 16'd0);
    for (int p = 0; p < 3; p++) begin
      measure_period(len, hi, mh);
      chk(len == 2, "R9", "small N clamped to 2", len, 2);
      chk(hi == 1, "R6", "square high for M=2", hi, 1);
    end
  endtask

  task automatic test_long(input logic [15:0] k);
    int diff = 0;
    @(negedge clk);
    rst_n = 1'b0; n_div = 12'd2; k_frac = k; mon_en = 1'b0;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    while (idx0 <= 65536 || idx1 <= 65536) @(negedge clk);
    chk(cnt0 == int'(k), "R4", "N+1 count over 65536 periods", cnt0, int'(k));
    chk(mis0 == 0, "R3", "undithered sequence vs model", mis0, 0);
    chk(mis1 == 0, "R7", "dithered sequence vs model", mis1, 0);
    chk(cnt1 >= int'(k) - 2 && cnt1 <= int'(k) + 2, "R7", "dithered N+1 count", cnt1, int'(k));
    for (int i = 0; i < 65536; i++) if (seq0[i] !== seq1[i]) diff++;
    chk(diff > 0, "R7", "dither changes pattern (diff count)", diff, 1);
    mon_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 195000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    test_integer(12'd5);
    test_integer(12'd6);
    test_fraction(12'd7, 16'h8000, 24);
    test_fraction(12'd3, 16'h5555, 40);
    test_fraction(12'd4, 16'hFFFF, 20);
    test_resample();
    test_clamp(12'd0);
    test_clamp(12'd1);
    test_long(16'd12345);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule